// File: doc/BRIEF.md
# Bus Address Match Patch Unit

The unit snoops a processor's memory bus on two independent channels. Each channel holds a compare address, an optional access-direction condition and a patch data word. When a snooped access meets a channel's conditions, the channel sets a sticky match flag. The channel's two enable bits then decide what the match does. With the interrupt enable set, the flag drives a shared break interrupt. With only the patch enable set, the matching read has its returned data replaced by the patch word on the way back to the processor. On channel 0, setting both enables turns the channel into a data-value break: the bus data must also equal the patch word before the channel matches. Channel 1 is held silent while either of two external mode inputs is high.

Software reaches the unit through a small register port. Writes are single-cycle strobes and reads are combinational. The snoop input is a valid-only stream. The unit only observes the bus, so it never exerts back-pressure and has no ready signal: every cycle with `snp_valid` high is one bus access, and is evaluated in that same cycle. The read-data path from memory to the processor is a combinational multiplexer with no added latency.

Top module: `mp_patch_unit`

## Requirements
- R1: After reset the control register (offset 0) and the flag register (offset 1) read 0, `brk_irq` is low, and `cpu_rdata` equals `mem_rdata`.
- R2: A snooped access with `snp_valid` high and `snp_addr` equal to a channel's compare address sets that channel's flag (bit 0 for channel 0, bit 1 for channel 1 of offset 1) at the next clock edge. The flag then stays set until it is cleared. Compare addresses sit at offsets 2 and 3.
- R3: Writing the flag register clears each flag whose data bit is 0. A data bit of 1 leaves that flag unchanged.
- R4: When a clear of a flag and a match on that channel happen in the same cycle, the flag ends up set.
- R5: A register read with `reg_rmw` high returns every flag bit of offset 1 as 1. With `reg_rmw` low, the read returns the true flag values.
- R6: Control bits for channel n start at bit 4n: interrupt enable at +0, patch enable at +1, type-compare enable at +2 and expected direction at +3 (1 means write). With type-compare enable at 0, the access direction is ignored. With it at 1, a match also needs `snp_write` to equal the expected direction.
- R7: `brk_irq` is high exactly while some channel has both its flag and its interrupt enable set. It stays high until a register write removes that condition.
- R8: On channel 0 with both interrupt enable and patch enable set, a match also needs the bus data to equal patch word 0 (offset 4). The bus data is `snp_wdata` on a write and `mem_rdata` on a read.
- R9: For a channel with patch enable 1 and interrupt enable 0, a matching read drives that channel's patch word (offsets 4 and 5) onto `cpu_rdata` in the same cycle. Channel 0 wins if both channels patch. Writes, misses and idle cycles pass `mem_rdata` through unchanged.
- R10: While `mask_mode` or `range_mode` is high, channel 1 does not match and its flag is not set. Channel 0 is unaffected.
- R11: A cycle with `snp_valid` low sets no flag and patches no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rmw | input | 1 | Current read belongs to a read-modify-write |
| reg_rdata | output | 16 | Register read data (combinational) |
| snp_valid | input | 1 | Snooped bus access present this cycle |
| snp_addr | input | 16 | Snooped access address |
| snp_write | input | 1 | Snooped access is a write |
| snp_wdata | input | 16 | Snooped write data |
| mem_rdata | input | 16 | Read data returned by memory |
| cpu_rdata | output | 16 | Read data delivered to the processor |
| mask_mode | input | 1 | Address-mask mode active; silences channel 1 |
| range_mode | input | 1 | Address-range mode active; silences channel 1 |
| brk_irq | output | 1 | Break interrupt level |

## Verification
The assertions assume that the snoop inputs and the register strobe are synchronous and stable across each rising edge. They also assume that the only route by which a flag or an enable can fall is a register write. The bench keeps to this by changing every input on the falling edge and holding it for a whole cycle. Every flag clear and every enable change goes through the register port, so a high interrupt level never drops on a cycle without a write. The mode inputs are set and held before the accesses they are meant to block.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_FLAGS = 1;
  localparam int OFS_ADDR  = 2;
  localparam int CFG_BITS  = 4;

  typedef struct packed {
    logic trw;
    logic tce;
    logic pe;
    logic ie;
  } mp_cfg_t;
endpackage

// File: rtl/mp_regs.sv
module mp_regs
  import mp_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NCH = 2,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           reg_rmw,
  input  logic [NCH-1:0] flags,
  output logic [DW-1:0]  reg_rdata,
  output mp_cfg_t        cfg      [NCH],
  output logic [AW-1:0]  cmp_addr [NCH],
  output logic [DW-1:0]  patch    [NCH],
  output logic [NCH-1:0] flag_clr
);
  localparam int CTRL_W  = CFG_BITS * NCH;
  localparam int PATCH_B = OFS_ADDR + NCH;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (reg_we && reg_addr == RAW'(OFS_CTRL)) begin
      ctrl_q <= reg_wdata[CTRL_W-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_addr[i] <= '0;
        patch[i]    <= '0;
      end else if (reg_we) begin
        if (reg_addr == RAW'(OFS_ADDR + i)) cmp_addr[i] <= reg_wdata[AW-1:0];
        if (reg_addr == RAW'(PATCH_B + i))  patch[i]    <= reg_wdata;
      end
    end
    assign cfg[i]      = mp_cfg_t'(ctrl_q[CFG_BITS*i +: CFG_BITS]);
    assign flag_clr[i] = reg_we && (reg_addr == RAW'(OFS_FLAGS)) && !reg_wdata[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(OFS_CTRL)) begin
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    end else if (reg_addr == RAW'(OFS_FLAGS)) begin
      reg_rdata[NCH-1:0] = reg_rmw ? {NCH{1'b1}} : flags;
    end
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == RAW'(OFS_ADDR + i)) reg_rdata[AW-1:0] = cmp_addr[i];
      if (reg_addr == RAW'(PATCH_B + i))  reg_rdata = patch[i];
    end
  end

  // R5: a read-modify-write read of the flag register shows all flags set
  a_r5_rmw_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rmw && reg_addr == RAW'(OFS_FLAGS)) |-> (&reg_rdata[NCH-1:0]));
endmodule

// File: rtl/mp_channel.sv
module mp_channel
  import mp_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter bit DATA_BREAK = 1'b0,
  parameter bit GATED      = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mp_cfg_t       cfg,
  input  logic [AW-1:0] cmp_addr,
  input  logic [DW-1:0] patch,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic          snp_write,
  input  logic [DW-1:0] bus_data,
  input  logic          mode_block,
  input  logic          clr,
  output logic          hit,
  output logic          patch_sel,
  output logic          flag
);
  logic addr_ok, type_ok, data_ok, blocked;

  always_comb begin
    addr_ok   = snp_valid && (snp_addr == cmp_addr);
    type_ok   = !cfg.tce || (snp_write == cfg.trw);
    data_ok   = !(DATA_BREAK && cfg.ie && cfg.pe) || (bus_data == patch);
    blocked   = GATED && mode_block;
    hit       = addr_ok && type_ok && data_ok && !blocked;
    patch_sel = hit && cfg.pe && !cfg.ie && !snp_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R2: a set flag holds without a clear
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R4: a match wins over a simultaneous clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R11: only a match can raise the flag
  a_r11_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !snp_valid) |=> !flag);
  // R10: blocked channel never raises its flag
  a_r10_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (GATED && mode_block && !flag) |=> !flag);
endmodule

// File: rtl/mp_patch_unit.sv
module mp_patch_unit
  import mp_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NCH = 2,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           reg_rmw,
  output logic [DW-1:0]  reg_rdata,
  input  logic           snp_valid,
  input  logic [AW-1:0]  snp_addr,
  input  logic           snp_write,
  input  logic [DW-1:0]  snp_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic           mask_mode,
  input  logic           range_mode,
  output logic           brk_irq
);
  mp_cfg_t        cfg      [NCH];
  logic [AW-1:0]  cmp_addr [NCH];
  logic [DW-1:0]  patch    [NCH];
  logic [NCH-1:0] flag_clr, flags, hits, psel;
  logic [DW-1:0]  bus_data;
  logic           mode_block;

  assign bus_data   = snp_write ? snp_wdata : mem_rdata;
  assign mode_block = mask_mode || range_mode;

  mp_regs #(.AW(AW), .DW(DW), .NCH(NCH), .RAW(RAW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rmw(reg_rmw), .flags(flags),
    .reg_rdata(reg_rdata), .cfg(cfg), .cmp_addr(cmp_addr),
    .patch(patch), .flag_clr(flag_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mp_channel #(
      .AW(AW), .DW(DW),
      .DATA_BREAK(i == 0),
      .GATED(i != 0)
    ) ch_i (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[i]), .cmp_addr(cmp_addr[i]),
      .patch(patch[i]), .snp_valid(snp_valid), .snp_addr(snp_addr),
      .snp_write(snp_write), .bus_data(bus_data), .mode_block(mode_block),
      .clr(flag_clr[i]), .hit(hits[i]), .patch_sel(psel[i]), .flag(flags[i])
    );
  end

  always_comb begin
    brk_irq   = 1'b0;
    cpu_rdata = mem_rdata;
    for (int i = NCH - 1; i >= 0; i--) begin
      brk_irq = brk_irq || (flags[i] && cfg[i].ie);
      if (psel[i]) cpu_rdata = patch[i];
    end
  end

  // R7: interrupt level drops only through a register write
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_irq && !reg_we) |=> brk_irq);
  // R9: writes and idle cycles never see patched data
  a_r9_no_patch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_valid || snp_write) |-> (cpu_rdata == mem_rdata));
endmodule

// File: tb/mp_patch_unit_tb_top.sv
`timescale 1ns/1ps
module mp_patch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_rmw = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        snp_valid = 1'b0, snp_write = 1'b0;
  logic [15:0] snp_addr = '0, snp_wdata = '0, mem_rdata = 16'h5A5A, cpu_rdata;
  logic        mask_mode = 1'b0, range_mode = 1'b0, brk_irq;
  int total = 0, fails = 0;
  logic [15:0] v, last_rd;

  localparam logic [15:0] A0 = 16'h1230, A1 = 16'h4561;

  always #4 clk = ~clk;

  mp_patch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rmw(reg_rmw), .reg_rdata(reg_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_write(snp_write),
    .snp_wdata(snp_wdata), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
    .mask_mode(mask_mode), .range_mode(range_mode), .brk_irq(brk_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic rmw, output logic [15:0] val);
    @(negedge clk);
    reg_addr = 3'(a); reg_rmw = rmw;
    #1 val = reg_rdata;
    reg_rmw = 1'b0;
  endtask

  task automatic snoop(input logic [15:0] a, input logic w, input logic [15:0] wd,
                       input logic [15:0] md);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_write = w; snp_wdata = wd; mem_rdata = md;
    #1 last_rd = cpu_rdata;
    @(negedge clk);
    snp_valid = 1'b0; mem_rdata = 16'h5A5A;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 1'b0, v); chk("R1 ctrl", v, 16'h0);
    rd(1, 1'b0, v); chk("R1 flags", v, 16'h0);
    #1 chk("R1 irq", {15'b0, brk_irq}, 16'h0);
    chk("R1 cpu_rdata", cpu_rdata, mem_rdata);
    wr(2, A0); wr(3, A1);

    // R2 / R6 sweep: channel, type compare, direction, hit
    for (int ch = 0; ch < 2; ch++)
      for (int tce = 0; tce < 2; tce++)
        for (int trw = 0; trw < 2; trw++)
          for (int w = 0; w < 2; w++)
            for (int h = 0; h < 2; h++) begin
              logic [15:0] a;
              int exp;
              wr(0, ((tce << 2) | (trw << 3)) << (4 * ch));
              wr(1, 0);
              a = (ch == 0) ? A0 : A1;
              if (h == 0) a = a ^ 16'h0100;
              snoop(a, w[0], 16'h0, 16'h5A5A);
              exp = (h == 1 && (tce == 0 || w == trw)) ? (1 << ch) : 0;
              rd(1, 1'b0, v); chk("R2 R6 flag sweep", v, 16'(exp));
              @(negedge clk);
              rd(1, 1'b0, v); chk("R2 sticky", v, 16'(exp));
            end

    // R11 no valid, no match
    wr(0, 0); wr(1, 0);
    @(negedge clk); snp_valid = 1'b0; snp_addr = A0;
    @(negedge clk);
    rd(1, 1'b0, v); chk("R11 idle", v, 16'h0);

    // R3 clearing
    snoop(A0, 1'b0, 0, 16'h5A5A); snoop(A1, 1'b0, 0, 16'h5A5A);
    rd(1, 1'b0, v); chk("R3 both set", v, 16'h3);
    wr(1, 16'hFFFF); rd(1, 1'b0, v); chk("R3 write one keeps", v, 16'h3);
    wr(1, 16'h0002); rd(1, 1'b0, v); chk("R3 clear ch0 only", v, 16'h2);
    wr(1, 16'h0000); rd(1, 1'b0, v); chk("R3 clear all", v, 16'h0);

    // R5 rmw read
    snoop(A0, 1'b0, 0, 16'h5A5A);
    rd(1, 1'b1, v); chk("R5 rmw read", v, 16'h3);
    rd(1, 1'b0, v); chk("R5 plain read", v, 16'h1);

    // R4 set beats clear
    wr(1, 0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0;
    snp_valid = 1'b1; snp_addr = A0; snp_write = 1'b0;
    @(negedge clk);
    reg_we = 1'b0; snp_valid = 1'b0;
    rd(1, 1'b0, v); chk("R4 set wins", v, 16'h1);

    // R7 interrupt sweep
    for (int k = 0; k < 16; k++) begin
      int ie0, ie1, f0, f1;
      ie0 = k & 1; ie1 = (k >> 1) & 1; f0 = (k >> 2) & 1; f1 = (k >> 3) & 1;
      wr(0, 0); wr(1, 0);
      if (f0 == 1) snoop(A0, 1'b0, 0, 16'h5A5A);
      if (f1 == 1) snoop(A1, 1'b0, 0, 16'h5A5A);
      wr(0, ie0 | (ie1 << 4));
      @(negedge clk); #1;
      chk("R7 irq sweep", {15'b0, brk_irq}, 16'((ie0 & f0) | (ie1 & f1)));
    end
    wr(0, 16'h0011); wr(1, 0); snoop(A1, 1'b0, 0, 16'h5A5A);
    repeat (3) @(negedge clk); #1 chk("R7 level held", {15'b0, brk_irq}, 16'h1);
    wr(1, 0); #1 chk("R7 cleared", {15'b0, brk_irq}, 16'h0);

    // R8 data-value break on channel 0
    wr(4, 16'hBEEF); wr(0, 16'h0003); wr(1, 0);
    snoop(A0, 1'b0, 0, 16'h1111);
    rd(1, 1'b0, v); chk("R8 data mismatch", v, 16'h0);
    chk("R8 no patch in break", last_rd, 16'h1111);
    snoop(A0, 1'b0, 0, 16'hBEEF);
    rd(1, 1'b0, v); chk("R8 read data match", v, 16'h1);
    wr(1, 0); snoop(A0, 1'b1, 16'hBEEF, 16'h2222);
    rd(1, 1'b0, v); chk("R8 write data match", v, 16'h1);

    // R9 patch sweep
    wr(5, 16'hC0DE);
    for (int k = 0; k < 16; k++) begin
      int ie, pe, ch, w;
      logic [15:0] exp;
      ie = k & 1; pe = (k >> 1) & 1; ch = (k >> 2) & 1; w = (k >> 3) & 1;
      wr(0, (ie | (pe << 1)) << (4 * ch));
      snoop(ch == 0 ? A0 : A1, w[0], 16'hBEEF, 16'h7777);
      exp = (pe == 1 && ie == 0 && w == 0) ? (ch == 0 ? 16'hBEEF : 16'hC0DE) : 16'h7777;
      chk("R9 patch sweep", last_rd, exp);
    end
    wr(0, 16'h0022);
    snoop(A0 ^ 16'h0001, 1'b0, 0, 16'h3333); chk("R9 miss passthrough", last_rd, 16'h3333);
    wr(3, A0); snoop(A0, 1'b0, 0, 16'h3333); chk("R9 ch0 priority", last_rd, 16'hBEEF);
    wr(3, A1);

    // R10 mode gating
    wr(0, 0);
    for (int k = 0; k < 4; k++) begin
      wr(1, 0);
      mask_mode = k[0]; range_mode = k[1];
      snoop(A1, 1'b0, 0, 16'h5A5A); snoop(A0, 1'b0, 0, 16'h5A5A);
      rd(1, 1'b0, v); chk("R10 gating", v, (k == 0) ? 16'h3 : 16'h1);
    end
    mask_mode = 1'b0; range_mode = 1'b0;
    wr(0, 16'h0020); wr(1, 0); range_mode = 1'b1;
    snoop(A1, 1'b0, 0, 16'h4444); chk("R10 no patch when gated", last_rd, 16'h4444);
    range_mode = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule